// File: doc/BRIEF.md
# Buffered-Transmit SPI Master

This block is the master side of a four-wire serial peripheral link. Software places one byte in a holding register. The block copies it into an 8-bit shift register and clocks it out on MOSI, most significant bit first. At the same time it gathers eight bits from MISO into a receive register. The serial clock runs at the system clock divided by an even ratio. Its idle level (`cpol`) and its phase (`cpha`) are selectable. With `cpha` at 0, data is sampled on the first SCK edge of each bit. With `cpha` at 1, data is sampled on the second edge.

While a transfer runs, software may queue the next byte. The holding register is copied into the shifter only at a transfer boundary: when a transfer starts from idle, or when the trailing gap of a finished transfer ends. A write made during the first clock pulse of a back-to-back transfer therefore cannot reload the shifter or raise the transmit-empty flag a second time.

When fault detection is enabled, the select line becomes an input. If another device pulls it low, the block aborts the current transfer and raises a fault flag. It then turns off the drivers of SCK, MOSI, select and MISO, and stays off until software clears the flag.

Top module: `spi_xmit_master`

## Requirements
- R1: After reset, `tx_empty` is 1, `rx_full` is 0, `fault` is 0, `ss_o` is 1 and `sck_o` equals `cpol`.
- R2: Each transfer moves 8 bits on MOSI, most significant bit first. The two edges of one SCK period are `div_half`+1 clocks apart, so consecutive sampling edges within a byte are 2*(`div_half`+1) clocks apart. Outside a transfer, SCK rests at `cpol`.
- R3: MISO is shifted in, most significant bit first. `rx_full` rises when the eighth bit is sampled, with that byte on `rd_data`. A cycle with `rd_en` high clears `rx_full`.
- R4: With `cpha`=0, the first SCK edge after select falls is a sampling edge. With `cpha`=1, the first edge only launches data, and the second edge samples.
- R5: A write with `tx_empty`=1 is stored and clears `tx_empty`. A write with `tx_empty`=0 is ignored: the stored byte is unchanged.
- R6: `tx_empty` rises, and the held byte enters the shifter, only when a transfer starts from idle or at the end of a trailing gap. A write during the first SCK pulse of a back-to-back transfer leaves `tx_empty` at 0 for the rest of that transfer, and both bytes are sent intact.
- R7: If a byte is held when the trailing gap (one half period) ends, the next transfer starts at once with select kept low. From the last sampling edge of one byte to the first of the next is 3*(`div_half`+1) clocks.
- R8: Select falls one half period before the first bit's half period starts, so select-fall to first sampling edge is 2*(`div_half`+1) clocks. Select rises when the trailing gap ends with nothing held.
- R9: With `en` and `fault_en` high, `ss_oe` is 0. A low on `ss_i` sets `fault` within 3 clocks and aborts the transfer. While `fault` is 1, `sck_oe`, `mosi_oe`, `ss_oe` and `miso_oe` are all 0. `miso_oe` is never 1.
- R10: `fault_clr` clears `fault` only while the synchronised `ss_i` is high. While `fault` is set, no transfer starts. A byte written during the fault is held and sent after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Master enable |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase: 0 samples on the first edge, 1 on the second |
| fault_en | input | 1 | Use select as a fault-detect input |
| div_half | input | 8 | Half SCK period in clocks, minus one |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe for the receive data; clears `rx_full` |
| fault_clr | input | 1 | Clear the fault flag |
| tx_empty | output | 1 | Holding register can accept a byte |
| rx_full | output | 1 | A received byte is waiting |
| rd_data | output | 8 | Last received byte |
| fault | output | 1 | Mode-fault flag |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out driver enable |
| miso_i | input | 1 | Serial data in |
| miso_oe | output | 1 | MISO driver enable (held low in master mode) |
| ss_o | output | 1 | Select, active low |
| ss_oe | output | 1 | Select driver enable |
| ss_i | input | 1 | Select pin level as seen from outside |

## Verification
The block is exercised in five ways:
- **Lone bytes in both clock phases.** These separate a correct phase choice from a swapped one, through the edge count at the first sample and the captured MOSI byte.
- **A queued byte followed by a write while the register is full.** This shows whether the extra write is dropped.
- **Back-to-back pairs with a write during the first pulse of the second byte.** These tell a boundary-only load apart from a mid-transfer reload, using the `tx_empty` level, the gap between bytes and the integrity of all three bytes.
- **A select pulled low in the middle of a byte.** This checks the abort and the driver shutdown, and that a clear attempted while the line is still low has no effect.
- **Received data.** A model slave shifts a distinct pattern on MISO for every transfer, so a bit-order or sampling-edge fault shows up as a wrong received byte.

// File: rtl/spi_xm_pkg.sv
package spi_xm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_XFER  = 2'd2,
    ST_TRAIL = 2'd3
  } xm_state_e;
endpackage

// File: rtl/spi_xm_baud.sv
module spi_xm_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q >= div_half);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_xm_txbuf.sv
module spi_xm_txbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] data,
  output logic          empty
);
  logic [DW-1:0] data_q, data_d;
  logic          empty_q, empty_d;
  logic          accept;

  assign accept = wr_en && empty_q;

  always_comb begin
    data_d  = data_q;
    empty_d = empty_q;
    if (take)        empty_d = 1'b1;
    else if (accept) empty_d = 1'b0;
    if (accept)      data_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      data_q  <= data_d;
      empty_q <= empty_d;
    end
  end

  assign data  = data_q;
  assign empty = empty_q;

  // R5
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_q && wr_en) |=> $stable(data_q));

  // R6
  take_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !empty_q);
endmodule

// File: rtl/spi_xm_fault.sv
module spi_xm_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic ss_i,
  input  logic clr,
  output logic fault
);
  logic ss_m_q, ss_s_q;
  logic fault_q, fault_d;
  logic set;

  assign set = arm && !ss_s_q;

  always_comb begin
    fault_d = fault_q;
    if (set)      fault_d = 1'b1;
    else if (clr) fault_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_m_q  <= 1'b1;
      ss_s_q  <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      ss_m_q  <= ss_i;
      ss_s_q  <= ss_m_q;
      fault_q <= fault_d;
    end
  end

  assign fault = fault_q;

  // R9
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> !$past(ss_i, 3));
endmodule

// File: rtl/spi_xm_engine.sv
module spi_xm_engine
  import spi_xm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          tick,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          buf_full,
  input  logic [DW-1:0] buf_data,
  input  logic          miso_i,
  input  logic          rd,
  output logic          take,
  output logic          active,
  output logic          sck,
  output logic          mosi,
  output logic [DW-1:0] rx_data,
  output logic          rx_full
);
  localparam int HALVES = 2 * DW;
  localparam int HW     = $clog2(HALVES);
  localparam logic [HW-1:0] LAST_H = HW'(HALVES - 1);
  localparam logic [HW-1:0] PRE_H  = HW'(HALVES - 2);

  xm_state_e     state_q, state_d;
  logic [HW-1:0] half_q, half_d;
  logic [DW-1:0] tx_q, tx_d;
  logic [DW-1:0] rx_q, rx_d;
  logic [DW-1:0] rxd_q, rxd_d;
  logic          full_q, full_d;
  logic          done;
  logic [DW-1:0] rx_next;

  assign rx_next = {rx_q[DW-2:0], miso_i};

  always_comb begin
    state_d = state_q;
    half_d  = half_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    rxd_d   = rxd_q;
    take    = 1'b0;
    done    = 1'b0;
    if (!go) begin
      state_d = ST_IDLE;
      half_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (buf_full) begin
            take    = 1'b1;
            tx_d    = buf_data;
            state_d = ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            state_d = ST_XFER;
            half_d  = '0;
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (!half_q[0]) begin
              rx_d = rx_next;
              if (half_q == PRE_H) begin
                rxd_d = rx_next;
                done  = 1'b1;
              end
              half_d = half_q + HW'(1);
            end else if (half_q == LAST_H) begin
              state_d = ST_TRAIL;
              half_d  = '0;
            end else begin
              tx_d   = {tx_q[DW-2:0], 1'b0};
              half_d = half_q + HW'(1);
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            if (buf_full) begin
              take    = 1'b1;
              tx_d    = buf_data;
              state_d = ST_XFER;
              half_d  = '0;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    full_d = full_q;
    if (done)    full_d = 1'b1;
    else if (rd) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      half_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rxd_q   <= '0;
      full_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      rxd_q   <= rxd_d;
      full_q  <= full_d;
    end
  end

  assign active  = (state_q != ST_IDLE);
  assign sck     = (state_q == ST_XFER) ? (cpol ^ cpha ^ half_q[0]) : cpol;
  assign mosi    = tx_q[DW-1];
  assign rx_data = rxd_q;
  assign rx_full = full_q;

  // R3
  rx_full_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(state_q == ST_XFER && tick));
endmodule

// File: rtl/spi_xmit_master.sv
module spi_xmit_master #(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             fault_en,
  input  logic [DIV_W-1:0] div_half,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic             fault_clr,
  output logic             tx_empty,
  output logic             rx_full,
  output logic [DW-1:0]    rd_data,
  output logic             fault,
  output logic             sck_o,
  output logic             sck_oe,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_oe,
  output logic             ss_o,
  output logic             ss_oe,
  input  logic             ss_i
);
  logic          go, tick, take, active, buf_empty;
  logic [DW-1:0] buf_data;
  logic          out_en;

  assign go     = en && !fault;
  assign out_en = en && !fault;

  spi_xm_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(active), .div_half(div_half), .tick(tick)
  );

  spi_xm_txbuf #(.DW(DW)) u_txbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .data(buf_data), .empty(buf_empty)
  );

  spi_xm_fault u_fault (
    .clk(clk), .rst_n(rst_n), .arm(en && fault_en), .ss_i(ss_i),
    .clr(fault_clr), .fault(fault)
  );

  spi_xm_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .tick(tick), .cpol(cpol), .cpha(cpha),
    .buf_full(!buf_empty), .buf_data(buf_data), .miso_i(miso_i), .rd(rd_en),
    .take(take), .active(active), .sck(sck_o), .mosi(mosi_o),
    .rx_data(rd_data), .rx_full(rx_full)
  );

  assign tx_empty = buf_empty;
  assign ss_o     = !active;
  assign sck_oe   = out_en;
  assign mosi_oe  = out_en;
  assign ss_oe    = out_en && !fault_en;
  assign miso_oe  = 1'b0;

  // R6
  load_at_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(sck_o == cpol));

  // R9
  fault_drivers_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(sck_oe || mosi_oe || ss_oe || miso_oe));
endmodule

// File: tb/spi_xmit_master_bench.sv
module spi_xmit_master_bench;
  localparam int DIVH = 3;
  localparam int H    = DIVH + 1;

  logic clk = 1'b0;
  logic rst_n, en, cpol, cpha, fault_en, wr_en, rd_en, fault_clr, miso_i, ss_i;
  logic [7:0] div_half, wr_data, rd_data;
  logic tx_empty, rx_full, fault, sck_o, sck_oe, mosi_o, mosi_oe, miso_oe, ss_o, ss_oe;

  always #2.5 clk = ~clk;

  spi_xmit_master u_spi_xmit_master (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha), .fault_en(fault_en),
    .div_half(div_half), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .fault_clr(fault_clr), .tx_empty(tx_empty), .rx_full(rx_full), .rd_data(rd_data),
    .fault(fault), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_oe(miso_oe), .ss_o(ss_o), .ss_oe(ss_oe), .ss_i(ss_i)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];
  bit abort_ok = 0;
  int samples_total = 0, bytes_done = 0, ss_rises = 0;
  int first_gap = 0, first_edges = 0, lead_gap = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] slave_byte(input int n);
    return 8'(n * 29) ^ 8'hA7;
  endfunction

  // Monitor: rebuilds MOSI bytes, plays the slave on MISO, drains the receive side.
  initial begin
    int cyc = 0, last_s = 0, fall_cyc = 0, edges = 0, bitidx = 0, n = 0;
    bit from_idle = 0, rd_pend = 0, prev_sck = 0, prev_ss = 1;
    logic [7:0] cur = '0;
    logic [7:0] e;
    rd_en = 1'b0;
    miso_i = slave_byte(0)[7];
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        prev_sck = sck_o; prev_ss = ss_o;
        continue;
      end
      if (prev_ss && !ss_o) begin
        edges = 0; from_idle = 1; fall_cyc = cyc;
      end
      if (!ss_o && sck_o !== prev_sck) begin
        edges++;
        if (sck_o == (cpol ^ ~cpha)) begin
          cur = {cur[6:0], mosi_o};
          samples_total++;
          if (bitidx == 0) begin
            first_gap = cyc - last_s;
            if (from_idle) begin
              first_edges = edges; lead_gap = cyc - fall_cyc; from_idle = 0;
            end
          end else begin
            chk(cyc - last_s == 2 * H, "R2", "sample spacing", cyc - last_s, 2 * H);
          end
          last_s = cyc;
          bitidx++;
          if (bitidx == 8) begin
            if (exp_q.size() == 0) chk(0, "R2", "unexpected MOSI byte", cur, 0);
            else begin
              e = exp_q.pop_front();
              chk(cur == e, "R2", "MOSI byte", cur, e);
            end
            rx_q.push_back(slave_byte(n));
            n++; bitidx = 0; bytes_done++;
          end
          miso_i = slave_byte(n)[7 - bitidx];
        end
      end
      if (!prev_ss && ss_o) begin
        ss_rises++;
        if (bitidx != 0) begin
          if (abort_ok && exp_q.size() != 0) void'(exp_q.pop_front());
          else chk(0, "R9", "unexpected partial byte", bitidx, 0);
          n++; bitidx = 0;
          miso_i = slave_byte(n)[7];
        end
      end
      if (rd_pend) begin
        rd_en = 1'b0; rd_pend = 0;
        chk(rx_full == 1'b0, "R3", "rx_full cleared by read", rx_full, 0);
      end else if (rx_full) begin
        if (rx_q.size() == 0) chk(0, "R3", "unexpected rx_full", 1, 0);
        else begin
          e = rx_q.pop_front();
          chk(rd_data == e, "R3", "received byte", rd_data, e);
        end
        rd_en = 1'b1; rd_pend = 1;
      end
      prev_sck = sck_o; prev_ss = ss_o;
    end
  end

  // Driver
  task automatic send(input logic [7:0] b, input bit expect_out);
    if (expect_out) exp_q.push_back(b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_empty();
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || !ss_o) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic b2b_case(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    int s0, bd0, viol, r0;
    r0 = ss_rises;
    send(a, 1);
    wait_empty();
    send(b, 1);
    wait_empty();
    s0 = samples_total; bd0 = bytes_done;
    while (samples_total == s0) @(negedge clk);
    send(c, 1);
    chk(tx_empty == 1'b0, "R5", "write during first pulse stored", tx_empty, 0);
    viol = 0;
    while (bytes_done == bd0) begin
      if (tx_empty) viol++;
      @(negedge clk);
    end
    chk(viol == 0, "R6", "tx_empty rose during transfer", viol, 0);
    chk(first_gap == 3 * H, "R7", "gap between back-to-back bytes", first_gap, 3 * H);
    wait_idle();
    chk(ss_rises - r0 == 1, "R7", "select stayed low across the chain", ss_rises - r0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; cpol = 1'b0; cpha = 1'b0; fault_en = 1'b0;
    div_half = 8'(DIVH); wr_en = 1'b0; wr_data = '0; fault_clr = 1'b0; ss_i = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_empty == 1'b1, "R1", "tx_empty after reset", tx_empty, 1);
    chk(rx_full == 1'b0, "R1", "rx_full after reset", rx_full, 0);
    chk(fault == 1'b0, "R1", "fault after reset", fault, 0);
    chk(ss_o == 1'b1, "R1", "ss_o after reset", ss_o, 1);
    chk(sck_o == cpol, "R1", "sck idle after reset", sck_o, cpol);
    chk(miso_oe == 1'b0, "R9", "miso_oe in master mode", miso_oe, 0);

    // Lone byte, phase 0
    send(8'hA5, 1);
    wait_idle();
    chk(first_edges == 1, "R4", "cpha0 edges at first sample", first_edges, 1);
    chk(lead_gap == 2 * H, "R8", "select fall to first sample", lead_gap, 2 * H);
    chk(ss_o == 1'b1, "R8", "select released when nothing held", ss_o, 1);

    // Write while full is dropped
    send(8'h3C, 1);
    wait_empty();
    send(8'h5A, 1);
    chk(tx_empty == 1'b0, "R5", "accepted write clears tx_empty", tx_empty, 0);
    send(8'hFF, 0);
    chk(tx_empty == 1'b0, "R5", "tx_empty after ignored write", tx_empty, 0);
    wait_idle();
    chk(first_gap == 3 * H, "R7", "back-to-back gap", first_gap, 3 * H);

    // Write in first pulse, phase 0
    b2b_case(8'h81, 8'h7E, 8'hC3);

    // Phase 1, idle high
    cpha = 1'b1; cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk(sck_o == 1'b1, "R2", "sck idle at cpol=1", sck_o, 1);
    send(8'h96, 1);
    wait_idle();
    chk(first_edges == 2, "R4", "cpha1 edges at first sample", first_edges, 2);
    b2b_case(8'h12, 8'h34, 8'h56);

    // Mode fault
    cpha = 1'b0; cpol = 1'b0; fault_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(ss_oe == 1'b0, "R9", "select not driven with detection on", ss_oe, 0);
    abort_ok = 1;
    send(8'hE1, 1);
    wait_empty();
    begin
      int s0;
      s0 = samples_total;
      while (samples_total < s0 + 3) @(negedge clk);
    end
    ss_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(fault == 1'b1, "R9", "fault set by external select", fault, 1);
    chk({sck_oe, mosi_oe, ss_oe, miso_oe} == 4'b0, "R9", "drivers off in fault",
        {sck_oe, mosi_oe, ss_oe, miso_oe}, 0);
    chk(ss_o == 1'b1, "R9", "transfer aborted", ss_o, 1);
    send(8'h4D, 1);
    repeat (20) @(negedge clk);
    chk(tx_empty == 1'b0, "R10", "no start while fault set", tx_empty, 0);
    @(negedge clk); fault_clr = 1'b1; @(negedge clk); fault_clr = 1'b0;
    @(negedge clk);
    chk(fault == 1'b1, "R10", "clear ignored with select low", fault, 1);
    ss_i = 1'b1;
    repeat (3) @(negedge clk);
    fault_clr = 1'b1; @(negedge clk); fault_clr = 1'b0;
    @(negedge clk);
    chk(fault == 1'b0, "R10", "fault cleared", fault, 0);
    abort_ok = 0;
    wait_idle();
    chk(exp_q.size() == 0, "R10", "held byte sent after clear", exp_q.size(), 0);
    chk(rx_q.size() == 0, "R3", "all received bytes read", rx_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule